// File: doc/BRIEF.md
# Peer Mailbox Register Interface

This block is the register window that one peer of a shared-memory link sees. It is a 32-bit memory-mapped slave with five registers: the local peer number, the peer count, an interrupt enable, a doorbell and a local state word. It decodes only aligned full-word accesses. It holds the interrupt enable and the local state value. The block does not store doorbell data or state changes for the link. It turns them into single-cycle request pulses for an external event fabric. The fabric in turn signals each interrupt it delivers to this peer with a one-cycle pulse.

A separate privileged control port sets a one-shot mode. In this mode, every delivered interrupt clears the interrupt enable, so software has to re-arm reception after each event. Read data returns through a registered response one cycle after the request. Accesses that miss a register, that are misaligned or that are not full words have no side effect and read as zero.

Top module: `peer_mbox_regs`

## Requirements
- R1: After synchronous reset, the interrupt enable and the state word read 0, `irq_enable` is low, and no doorbell or state request is issued.
- R2: Offset 0x00 reads the zero-extended `LOCAL_ID` parameter and offset 0x04 reads the `MAX_PEERS` parameter. Writes to either offset change nothing.
- R3: At offset 0x08, only bit 0 (interrupt enable, driven out on `irq_enable`) is writable. Bits 31:1 always read 0.
- R4: A word write to offset 0x0C pulses `db_req_valid` for exactly the following cycle. The pulse carries `db_req_target` = write data bits 31:16 and `db_req_vector` = bits 15:0. Back-to-back writes give one pulse each, and a read of 0x0C returns 0.
- R5: Offset 0x10 holds a read/write state word. A write pulses `st_req_valid` in the following cycle with `st_req_value` equal to the written word, but only when that word differs from the value held before the write.
- R6: While one-shot mode is set, an `irq_deliver` pulse clears the interrupt enable by the next cycle. While one-shot mode is clear, delivery leaves the enable unchanged.
- R7: One-shot mode changes only through `priv_wr`/`priv_oneshot` and resets to 0. When a delivery in one-shot mode coincides with a bus write of the enable, the clear wins.
- R8: Reads of word-aligned offsets with no register return 0, and writes to them change nothing.
- R9: An access with address bits 1:0 not zero, or with `req_size` other than 2 (0 = byte, 1 = half, 2 = word), has no side effect and reads 0.
- R10: Every read request produces `rsp_valid` high for the single next cycle, with the data in `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read |
| rsp_rdata | output | 32 | Read response data |
| priv_wr | input | 1 | Strobe from the privileged control port |
| priv_oneshot | input | 1 | New one-shot mode value, taken when priv_wr is high |
| irq_deliver | input | 1 | Pulse from the fabric: an interrupt was delivered here |
| irq_enable | output | 1 | Current interrupt enable, used by the fabric |
| db_req_valid | output | 1 | Doorbell request pulse |
| db_req_target | output | 16 | Target peer of the doorbell |
| db_req_vector | output | 16 | Vector number of the doorbell |
| st_req_valid | output | 1 | State change request pulse |
| st_req_value | output | 32 | New state value |

## Verification
The assertions assume that `irq_deliver` and `priv_wr` are single-cycle strobes. They also assume that request inputs are held low during reset, because the response and doorbell checks look one cycle back to the request that caused them. The bench drives every input on the falling edge, raises each strobe for exactly one cycle and keeps all request inputs idle while reset is active. It also steers coincident events deliberately, such as a delivery in the same cycle as an enable write, so that the priority rule is exercised.

// File: rtl/peer_mbox_pkg.sv
package peer_mbox_pkg;

    localparam int DATA_W    = 32;
    localparam int PEER_ID_W = 16;
    localparam int VEC_W     = 16;

    // word offsets inside the register window
    localparam int OFF_ID    = 'h00;
    localparam int OFF_MAXP  = 'h04;
    localparam int OFF_ICTL  = 'h08;
    localparam int OFF_DBELL = 'h0C;
    localparam int OFF_STATE = 'h10;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_MAXP,
        SEL_ICTL,
        SEL_DBELL,
        SEL_STATE
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_acc_t;

    typedef struct packed {
        logic [PEER_ID_W-1:0] target;
        logic [VEC_W-1:0]     vector;
    } db_req_t;

    function automatic logic word_ok(input logic [1:0] lo, input logic [1:0] size);
        return (lo == 2'b00) && (size == SIZE_WORD);
    endfunction

endpackage

// File: rtl/mbox_addr_decode.sv
module mbox_addr_decode
    import peer_mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output bus_acc_t          acc
);

    always_comb begin
        acc.rd  = req_valid && !req_write;
        acc.wr  = req_valid && req_write;
        acc.sel = SEL_NONE;
        if (req_valid && word_ok(req_addr[1:0], req_size)) begin
            case (req_addr)
                ADDR_W'(OFF_ID):    acc.sel = SEL_ID;
                ADDR_W'(OFF_MAXP):  acc.sel = SEL_MAXP;
                ADDR_W'(OFF_ICTL):  acc.sel = SEL_ICTL;
                ADDR_W'(OFF_DBELL): acc.sel = SEL_DBELL;
                ADDR_W'(OFF_STATE): acc.sel = SEL_STATE;
                default:            acc.sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ictl_wr,
    input  logic ictl_bit,
    input  logic priv_wr,
    input  logic priv_oneshot,
    input  logic irq_deliver,
    output logic irq_en,
    output logic os_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en  <= 1'b0;
            os_mode <= 1'b0;
        end else begin
            if (priv_wr)
                os_mode <= priv_oneshot;
            // disarm on delivery has priority over a software write
            if (irq_deliver && os_mode)
                irq_en <= 1'b0;
            else if (ictl_wr)
                irq_en <= ictl_bit;
        end
    end

endmodule

// File: rtl/mbox_event_out.sv
module mbox_event_out
    import peer_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              db_wr,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              db_valid,
    output db_req_t           db_req,
    output logic              st_valid,
    output logic [DATA_W-1:0] st_value,
    output logic [DATA_W-1:0] state_q
);

    logic st_differs;
    assign st_differs = (wdata != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            db_valid <= 1'b0;
            db_req   <= '0;
            st_valid <= 1'b0;
            st_value <= '0;
            state_q  <= '0;
        end else begin
            db_valid <= db_wr;
            if (db_wr) begin
                db_req.target <= wdata[DATA_W-1 -: PEER_ID_W];
                db_req.vector <= wdata[VEC_W-1:0];
            end
            st_valid <= st_wr && st_differs;
            if (st_wr) begin
                state_q  <= wdata;
                st_value <= wdata;
            end
        end
    end

endmodule

// File: rtl/mbox_read_mux.sv
module mbox_read_mux
    import peer_mbox_pkg::*;
#(
    parameter int unsigned LOCAL_ID  = 0,
    parameter int unsigned MAX_PEERS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic              irq_en,
    input  logic [DATA_W-1:0] state_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [DATA_W-1:0] ID_WORD   = {{(DATA_W-PEER_ID_W){1'b0}}, PEER_ID_W'(LOCAL_ID)};
    localparam logic [DATA_W-1:0] MAXP_WORD = DATA_W'(MAX_PEERS);

    logic [DATA_W-1:0] word;

    always_comb begin
        case (sel)
            SEL_ID:    word = ID_WORD;
            SEL_MAXP:  word = MAXP_WORD;
            SEL_ICTL:  word = {{(DATA_W-1){1'b0}}, irq_en};
            SEL_STATE: word = state_q;
            default:   word = '0;   // doorbell and holes read zero
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? word : '0;
        end
    end

endmodule

// File: rtl/peer_mbox_regs.sv
module peer_mbox_regs
    import peer_mbox_pkg::*;
#(
    parameter int unsigned LOCAL_ID  = 0,
    parameter int unsigned MAX_PEERS = 2,
    parameter int          ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              priv_wr,
    input  logic              priv_oneshot,
    input  logic              irq_deliver,
    output logic              irq_enable,
    output logic              db_req_valid,
    output logic [15:0]       db_req_target,
    output logic [15:0]       db_req_vector,
    output logic              st_req_valid,
    output logic [31:0]       st_req_value
);

    bus_acc_t          acc;
    logic              ictl_wr, db_wr, st_wr;
    logic              os_mode;
    logic [DATA_W-1:0] state_q;
    db_req_t           db_req;

    mbox_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .acc       (acc)
    );

    assign ictl_wr = acc.wr && (acc.sel == SEL_ICTL);
    assign db_wr   = acc.wr && (acc.sel == SEL_DBELL);
    assign st_wr   = acc.wr && (acc.sel == SEL_STATE);

    mbox_irq_ctrl u_irq (
        .clk          (clk),
        .rst          (rst),
        .ictl_wr      (ictl_wr),
        .ictl_bit     (req_wdata[0]),
        .priv_wr      (priv_wr),
        .priv_oneshot (priv_oneshot),
        .irq_deliver  (irq_deliver),
        .irq_en       (irq_enable),
        .os_mode      (os_mode)
    );

    mbox_event_out u_evt (
        .clk      (clk),
        .rst      (rst),
        .db_wr    (db_wr),
        .st_wr    (st_wr),
        .wdata    (req_wdata),
        .db_valid (db_req_valid),
        .db_req   (db_req),
        .st_valid (st_req_valid),
        .st_value (st_req_value),
        .state_q  (state_q)
    );

    assign db_req_target = db_req.target;
    assign db_req_vector = db_req.vector;

    mbox_read_mux #(.LOCAL_ID(LOCAL_ID), .MAX_PEERS(MAX_PEERS)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (acc.rd),
        .sel       (acc.sel),
        .irq_en    (irq_enable),
        .state_q   (state_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
    import peer_mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              irq_deliver,
    input logic              irq_enable,
    input logic              os_mode,
    input logic [31:0]       state_q,
    input logic              db_req_valid,
    input logic [15:0]       db_req_target,
    input logic [15:0]       db_req_vector,
    input logic              st_req_valid,
    input logic [31:0]       st_req_value
);

    logic aligned_word, mapped, db_hit;
    assign aligned_word = (req_addr[1:0] == 2'b00) && (req_size == SIZE_WORD);
    assign mapped = aligned_word && (req_addr == ADDR_W'(OFF_ID) || req_addr == ADDR_W'(OFF_MAXP) ||
                    req_addr == ADDR_W'(OFF_ICTL) || req_addr == ADDR_W'(OFF_DBELL) ||
                    req_addr == ADDR_W'(OFF_STATE));
    assign db_hit = req_valid && req_write && aligned_word && (req_addr == ADDR_W'(OFF_DBELL));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_enable && state_q == 32'h0 && !db_req_valid && !st_req_valid));

    // R4
    db_source_chk: assert property (@(posedge clk) disable iff (rst)
        db_req_valid |-> $past(db_hit));

    // R4
    db_payload_chk: assert property (@(posedge clk) disable iff (rst)
        db_req_valid |-> ({db_req_target, db_req_vector} == $past(req_wdata)));

    // R5
    st_change_chk: assert property (@(posedge clk) disable iff (rst)
        st_req_valid |-> (st_req_value == state_q && state_q != $past(state_q)));

    // R6
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_deliver && os_mode) |=> !irq_enable);

    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(mapped)) |-> (rsp_rdata == 32'h0));

    // R9
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !aligned_word) |=> $stable(state_q));

    // R10
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && !req_write));

endmodule

bind peer_mbox_regs mbox_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .irq_deliver   (irq_deliver),
    .irq_enable    (irq_enable),
    .os_mode       (os_mode),
    .state_q       (state_q),
    .db_req_valid  (db_req_valid),
    .db_req_target (db_req_target),
    .db_req_vector (db_req_vector),
    .st_req_valid  (st_req_valid),
    .st_req_value  (st_req_value)
);

// File: tb/sim_peer_mbox_regs.sv
`timescale 1ns/1ps
module sim_peer_mbox_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        priv_wr = 1'b0, priv_oneshot = 1'b0, irq_deliver = 1'b0;
    logic        irq_enable, db_req_valid, st_req_valid;
    logic [15:0] db_req_target, db_req_vector;
    logic [31:0] st_req_value;

    int n_chk = 0, n_bad = 0;
    int db_cnt = 0, st_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    peer_mbox_regs #(.LOCAL_ID(3), .MAX_PEERS(5), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .priv_wr(priv_wr),
        .priv_oneshot(priv_oneshot), .irq_deliver(irq_deliver), .irq_enable(irq_enable),
        .db_req_valid(db_req_valid), .db_req_target(db_req_target),
        .db_req_vector(db_req_vector), .st_req_valid(st_req_valid),
        .st_req_value(st_req_value)
    );

    always @(negedge clk) begin
        if (db_req_valid) db_cnt++;
        if (st_req_valid) st_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one write; returns at the falling edge where its results are visible
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_size = 2'd2;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v,
                      input logic [1:0] sz = 2'd2);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 0; req_size = 2'd2;
        d = rsp_rdata; v = rsp_valid;
    endtask

    task automatic deliver();
        @(negedge clk); irq_deliver = 1;
        @(negedge clk); irq_deliver = 0;
    endtask

    task automatic set_oneshot(input logic m);
        @(negedge clk); priv_wr = 1; priv_oneshot = m;
        @(negedge clk); priv_wr = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        chk("R1 irq_enable", {31'b0, irq_enable}, 0);
        rd(8'h08, d, v); chk("R1 ictl", d, 0); chk("R10 rsp_valid", {31'b0, v}, 1);
        rd(8'h10, d, v); chk("R1 state", d, 0);
        @(negedge clk); chk("R10 rsp_valid drops", {31'b0, rsp_valid}, 0);
        chk("R1 no db", db_cnt, 0); chk("R1 no st", st_cnt, 0);
    endtask

    task automatic t_const();
        logic [31:0] d; logic v;
        rd(8'h00, d, v); chk("R2 id", d, 32'd3);
        rd(8'h04, d, v); chk("R2 maxpeers", d, 32'd5);
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h0);
        rd(8'h00, d, v); chk("R2 id after write", d, 32'd3);
        rd(8'h04, d, v); chk("R2 maxpeers after write", d, 32'd5);
    endtask

    task automatic t_ictl();
        logic [31:0] d; logic v;
        wr(8'h08, 32'hFFFF_FFFF);
        chk("R3 irq_enable set", {31'b0, irq_enable}, 1);
        rd(8'h08, d, v); chk("R3 ictl masked", d, 1);
        wr(8'h08, 32'h0000_0002);
        rd(8'h08, d, v); chk("R3 ictl bit1 ignored", d, 0);
    endtask

    task automatic t_doorbell();
        logic [31:0] d; logic v; int c0;
        c0 = db_cnt;
        wr(8'h0C, 32'h0002_0007);
        chk("R4 db pulse", {31'b0, db_req_valid}, 1);
        chk("R4 db target", {16'b0, db_req_target}, 32'h2);
        chk("R4 db vector", {16'b0, db_req_vector}, 32'h7);
        @(negedge clk); chk("R4 db one cycle", {31'b0, db_req_valid}, 0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h0C; req_wdata = 32'hABCD_0001;
        @(negedge clk); req_wdata = 32'h1234_0009;
        @(negedge clk); req_valid = 0; req_write = 0;
        chk("R4 second payload", {db_req_target, db_req_vector}, 32'h1234_0009);
        @(negedge clk);
        chk("R4 back-to-back count", db_cnt - c0, 3);
        rd(8'h0C, d, v); chk("R4 db read zero", d, 0);
    endtask

    task automatic t_state();
        logic [31:0] d; logic v; int c0;
        c0 = st_cnt;
        wr(8'h10, 32'h0000_0055);
        chk("R5 st pulse", {31'b0, st_req_valid}, 1);
        chk("R5 st value", st_req_value, 32'h55);
        rd(8'h10, d, v); chk("R5 state readback", d, 32'h55);
        wr(8'h10, 32'h0000_0055);
        chk("R5 same value no pulse", {31'b0, st_req_valid}, 0);
        wr(8'h10, 32'h0);
        chk("R5 back to zero value", st_req_value, 0);
        @(negedge clk);
        chk("R5 pulse count", st_cnt - c0, 2);
    endtask

    task automatic t_oneshot();
        logic [31:0] d; logic v;
        wr(8'h08, 1);
        deliver();
        chk("R6 off: enable kept", {31'b0, irq_enable}, 1);
        set_oneshot(1);
        chk("R7 mode write alone keeps enable", {31'b0, irq_enable}, 1);
        deliver();
        chk("R6 on: enable cleared", {31'b0, irq_enable}, 0);
        rd(8'h08, d, v); chk("R6 ictl reads 0", d, 0);
        wr(8'h08, 1);
        chk("R6 re-armed", {31'b0, irq_enable}, 1);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h08; req_wdata = 1; irq_deliver = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; irq_deliver = 0;
        chk("R7 clear beats write", {31'b0, irq_enable}, 0);
        set_oneshot(0);
        wr(8'h08, 1); deliver();
        chk("R7 mode cleared via priv port", {31'b0, irq_enable}, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic v; int c0, c1;
        c0 = db_cnt; c1 = st_cnt;
        rd(8'h14, d, v); chk("R8 hole 0x14", d, 0);
        rd(8'h80, d, v); chk("R8 hole 0x80", d, 0);
        wr(8'h14, 32'h0); wr(8'hF0, 32'h0);
        rd(8'h08, d, v); chk("R8 ictl untouched", d, 1);
        rd(8'h10, d, v); chk("R8 state untouched", d, 0);
        chk("R8 no events", (db_cnt - c0) + (st_cnt - c1), 0);
    endtask

    task automatic t_misaligned();
        logic [31:0] d; logic v; int c0, c1;
        c0 = db_cnt; c1 = st_cnt;
        wr(8'h11, 32'h77);
        wr(8'h10, 32'h77, 2'd0);
        wr(8'h0C, 32'h0001_0001, 2'd1);
        wr(8'h09, 32'h0);
        rd(8'h10, d, v); chk("R9 state unchanged", d, 0);
        rd(8'h08, d, v); chk("R9 ictl unchanged", d, 1);
        chk("R9 no events", (db_cnt - c0) + (st_cnt - c1), 0);
        rd(8'h00, d, v, 2'd1); chk("R9 half read zero", d, 0);
        rd(8'h01, d, v); chk("R9 misaligned read zero", d, 0);
        chk("R10 rsp on bad read", {31'b0, v}, 1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_const();
        t_ictl();
        t_doorbell();
        t_state();
        t_oneshot();
        t_unmapped();
        t_misaligned();
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule